// File: doc/BRIEF.md
# Speculative-Decision Receiver Back End with History-Filtered Edge Detector

This block is the digital stage that sits behind the sampler bank of a high-speed serial receiver. It runs in one of two modes. In two-level mode with one tap of decision feedback, two data slicers sit at the thresholds +h and -h. Each one has already decided the current bit on an assumption about the bit before it. The block keeps its own previous decision and uses it to pick which of the two speculative results is the real bit. This removes the one-unit-interval feedback loop from the analog path. In four-level mode the same three data slicers form a thermometer, and the block turns that thermometer into a two-bit level.

Each unit interval also brings three edge samples: one at zero threshold and two at the offset thresholds +h and -h. A channel with one trailing echo makes transitions cross at different voltages, depending on the bits that came before them. The block therefore looks at the recent decisions and chooses the one edge sampler whose threshold matches the actual crossing point. If no sampler matches, it makes no phase update. From the chosen sample it derives an early or late pulse for a bang-bang clock recovery loop.

Sample beats enter through a valid/ready handshake. Decisions leave through a valid/ready handshake with a single register stage. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer is taking its content that cycle. A held decision stays stable until the consumer takes it. The early/late pulses are plain control outputs, with no handshake.

Top module: `urx_dfe_cdr`

## Requirements
- R1: In two-level mode (`pam4_mode`=0), the decision for an accepted beat is `d_hi` if the previous decision bit is 1 and `d_lo` if it is 0. It appears as `dec_data` = {1'b0, bit}. After reset or a mode change, the previous bit counts as 0.
- R2: In four-level mode (`pam4_mode`=1), `dec_data[1]` is `d_mid` and `dec_data[0]` is `d_hi` when `d_mid` is 1 and `d_lo` when `d_mid` is 0. Thermometer levels 0..3 therefore map to the binary codes 0..3.
- R3: In two-level mode, a transition between the previous bit p and the current bit c (p != c) uses one edge sampler, chosen by the bit before p, called q. If q != p, `e_zero` is used. If q = p = 1, `e_pos` is used. If q = p = 0, `e_neg` is used.
- R4: In four-level mode, the edge sampler is chosen from the previous level P and the current level C. `e_zero` is used when C is the bitwise complement of P (0<->3, 1<->2). `e_pos` is used when both levels are 2 or 3. `e_neg` is used when both levels are 0 or 1. All other level pairs, including P = C, make no update.
- R5: Call a beat rising when c = 1 in two-level mode or C > P in four-level mode. For a qualified transition, `early` pulses when the chosen edge sample equals the rising flag, and `late` pulses when it differs. A beat with no transition produces neither pulse.
- R6: History has to be built up again after reset or any change of `pam4_mode`. Two-level mode needs two earlier decisions in the current mode before any pulse is made. Four-level mode needs one.
- R7: `early` and `late` are never high together. They are high only in the single cycle that follows an accepted beat, which gives one cycle of latency.
- R8: `in_ready` equals `!dec_valid || dec_ready`. An accepted beat sets `dec_valid` on the next cycle. While `dec_valid` is high and `dec_ready` is low, `dec_valid` and `dec_data` stay unchanged.
- R9: During reset, `dec_valid`, `early` and `late` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat per unit interval |
| rst_n | input | 1 | Active-low synchronous reset |
| pam4_mode | input | 1 | 1 = four-level decode, 0 = two-level with unrolled feedback tap |
| in_valid | input | 1 | Sample beat present |
| in_ready | output | 1 | Beat can be accepted this cycle |
| d_hi | input | 1 | Data slicer at threshold +h |
| d_mid | input | 1 | Data slicer at zero threshold (four-level mode only) |
| d_lo | input | 1 | Data slicer at threshold -h |
| e_zero | input | 1 | Edge sample at zero threshold |
| e_pos | input | 1 | Edge sample at threshold +h |
| e_neg | input | 1 | Edge sample at threshold -h |
| dec_valid | output | 1 | Decision register holds a symbol |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_data | output | SYM_W | Decided symbol |
| early | output | 1 | Clock phase early pulse |
| late | output | 1 | Clock phase late pulse |

## Verification
The bench builds the block with the default two-bit symbol width. With that width, every three-beat history of two-level decisions and every pair of four-level codes can be reached many times over a few thousand beats. A pseudo-random stream covers every slicer and edge sample combination under each history. It also switches mode at intervals and applies random consumer stalls, so the history restart and the hold behaviour are exercised alongside the edge selection.

// File: rtl/urx_pkg.sv
`timescale 1ns/1ps
package urx_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_POS  = 2'd2,
    SRC_NEG  = 2'd3
  } edge_src_e;
endpackage

// File: rtl/urx_unroll_sel.sv
`timescale 1ns/1ps
module urx_unroll_sel #(
  parameter int SYM_W = 2
) (
  input  logic             pam4,
  input  logic             prev_bit,
  input  logic             d_hi,
  input  logic             d_mid,
  input  logic             d_lo,
  output logic [SYM_W-1:0] sym
);
  always_comb begin
    sym = '0;
    if (pam4) begin
      sym[1] = d_mid;
      sym[0] = d_mid ? d_hi : d_lo;
    end else begin
      // speculative pick: previous decision resolves the unrolled tap
      sym[0] = prev_bit ? d_hi : d_lo;
    end
  end
endmodule

// File: rtl/urx_edge_qual.sv
`timescale 1ns/1ps
module urx_edge_qual
  import urx_pkg::*;
#(
  parameter int SYM_W = 2,
  parameter int CNT_W = 2
) (
  input  logic             pam4,
  input  logic [CNT_W-1:0] hist_cnt,
  input  logic [SYM_W-1:0] sym_m2,
  input  logic [SYM_W-1:0] sym_m1,
  input  logic [SYM_W-1:0] sym_cur,
  input  logic             e_zero,
  input  logic             e_pos,
  input  logic             e_neg,
  output logic             pulse_early,
  output logic             pulse_late
);
  edge_src_e src;
  logic      rising;
  logic      sample;

  always_comb begin
    src    = SRC_NONE;
    rising = 1'b0;
    if (pam4) begin
      rising = sym_cur > sym_m1;
      if (hist_cnt >= CNT_W'(1) && sym_cur != sym_m1) begin
        if ((sym_cur ^ sym_m1) == {SYM_W{1'b1}})
          src = SRC_ZERO;
        else if (sym_cur[SYM_W-1] && sym_m1[SYM_W-1] && sym_cur[SYM_W-2:0] != sym_m1[SYM_W-2:0])
          src = SRC_POS;
        else if (!sym_cur[SYM_W-1] && !sym_m1[SYM_W-1])
          src = SRC_NEG;
      end
    end else begin
      rising = sym_cur[0];
      if (hist_cnt >= CNT_W'(2) && sym_cur[0] != sym_m1[0]) begin
        if (sym_m2[0] != sym_m1[0])
          src = SRC_ZERO;
        else if (sym_m1[0])
          src = SRC_POS;
        else
          src = SRC_NEG;
      end
    end
  end

  always_comb begin
    case (src)
      SRC_ZERO: sample = e_zero;
      SRC_POS:  sample = e_pos;
      SRC_NEG:  sample = e_neg;
      default:  sample = 1'b0;
    endcase
    pulse_early = (src != SRC_NONE) && (sample == rising);
    pulse_late  = (src != SRC_NONE) && (sample != rising);
  end
endmodule

// File: rtl/urx_dfe_cdr.sv
`timescale 1ns/1ps
module urx_dfe_cdr #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pam4_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             d_hi,
  input  logic             d_mid,
  input  logic             d_lo,
  input  logic             e_zero,
  input  logic             e_pos,
  input  logic             e_neg,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [SYM_W-1:0] dec_data,
  output logic             early,
  output logic             late
);
  localparam int HIST  = 2;
  localparam int CNT_W = $clog2(HIST + 1);

  logic             mode_q;
  logic [SYM_W-1:0] s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flush, accept;
  logic [SYM_W-1:0] s1_e, s2_e, cur_sym;
  logic [CNT_W-1:0] cnt_e, cnt_n;
  logic             upd_early, upd_late;

  assign flush    = (pam4_mode != mode_q);
  assign s1_e     = flush ? '0 : s1_q;
  assign s2_e     = flush ? '0 : s2_q;
  assign cnt_e    = flush ? '0 : cnt_q;
  assign cnt_n    = (cnt_e == CNT_W'(HIST)) ? cnt_e : cnt_e + CNT_W'(1);
  assign in_ready = !dec_valid || dec_ready;
  assign accept   = in_valid && in_ready;

  urx_unroll_sel #(.SYM_W(SYM_W)) i_sel (
    .pam4     (pam4_mode),
    .prev_bit (s1_e[0]),
    .d_hi     (d_hi),
    .d_mid    (d_mid),
    .d_lo     (d_lo),
    .sym      (cur_sym)
  );

  urx_edge_qual #(.SYM_W(SYM_W), .CNT_W(CNT_W)) i_qual (
    .pam4        (pam4_mode),
    .hist_cnt    (cnt_e),
    .sym_m2      (s2_e),
    .sym_m1      (s1_e),
    .sym_cur     (cur_sym),
    .e_zero      (e_zero),
    .e_pos       (e_pos),
    .e_neg       (e_neg),
    .pulse_early (upd_early),
    .pulse_late  (upd_late)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      s1_q   <= '0;
      s2_q   <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= pam4_mode;
      if (accept) begin
        s2_q  <= s1_e;
        s1_q  <= cur_sym;
        cnt_q <= cnt_n;
      end else begin
        s2_q  <= s2_e;
        s1_q  <= s1_e;
        cnt_q <= cnt_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
      early     <= 1'b0;
      late      <= 1'b0;
    end else begin
      early <= accept && upd_early;
      late  <= accept && upd_late;
      if (accept) begin
        dec_valid <= 1'b1;
        dec_data  <= cur_sym;
      end else if (dec_ready) begin
        dec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/urx_dfe_cdr_chk.sv
`timescale 1ns/1ps
module urx_dfe_cdr_chk #(
  parameter int SYM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pam4_mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic [SYM_W-1:0] dec_data,
  input logic             early,
  input logic             late
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(early && late));

  a_r7_pulse_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (early || late) |-> $past(in_valid && in_ready));

  a_r8_beat_fills_output: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> dec_valid);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_data)));

  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pam4_mode != $past(pam4_mode)) |=> (!early && !late));
endmodule

bind urx_dfe_cdr urx_dfe_cdr_chk #(.SYM_W(SYM_W)) i_chk (.*);

// File: tb/test_urx_dfe_cdr.sv
`timescale 1ns/1ps
module test_urx_dfe_cdr;
  localparam int SYM_W  = 2;
  localparam int CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n, pam4_mode, in_valid, in_ready, d_hi, d_mid, d_lo;
  logic e_zero, e_pos, e_neg, dec_valid, dec_ready, early, late;
  logic [SYM_W-1:0] dec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  urx_dfe_cdr #(.SYM_W(SYM_W)) i_urx_dfe_cdr (.*);

  // bench model state
  logic       m_mode, m_dv, m_early, m_late;
  logic [1:0] m_s1, m_s2, m_data;
  int         m_cnt;
  string      m_tag;
  logic [31:0] rs;

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * (CYCLES + 200));
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rs = 32'h1234_abcd;
    rst_n = 1'b0; pam4_mode = 1'b0; in_valid = 1'b0; dec_ready = 1'b0;
    d_hi = 0; d_mid = 0; d_lo = 0; e_zero = 0; e_pos = 0; e_neg = 0;
    m_mode = 0; m_dv = 0; m_early = 0; m_late = 0;
    m_s1 = 0; m_s2 = 0; m_data = 0; m_cnt = 0; m_tag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 dec_valid", 8'(dec_valid), 8'd0);
    chk("R9 early", 8'(early), 8'd0);
    chk("R9 late", 8'(late), 8'd0);
    chk("R9 in_ready", 8'(in_ready), 8'd1);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      logic acc, flush, prev, rise, smp, qual;
      logic [1:0] s1e, s2e, cur;
      int cnt_e;
      // compare what the last edge produced
      if (cyc > 0) begin
        chk("R8 dec_valid", 8'(dec_valid), 8'(m_dv));
        if (m_dv) chk(m_mode ? "R2 dec_data" : "R1 dec_data", 8'(dec_data), 8'(m_data));
        chk({m_tag, " early"}, 8'(early), 8'(m_early));
        chk({m_tag, " late"}, 8'(late), 8'(m_late));
        chk("R7 exclusive", 8'(early && late), 8'd0);
      end
      // stimulus
      rs = nxt(rs);
      if (cyc < 2000)      pam4_mode = (cyc / 300) % 2 == 1;
      else                 pam4_mode = (rs[31:27] == 5'd0) ? ~pam4_mode : pam4_mode;
      in_valid  = rs[1:0] != 2'b00;
      dec_ready = rs[3:2] != 2'b00;
      {d_lo, d_mid, d_hi} = rs[6:4];
      if (pam4_mode) begin
        // thermometer-consistent slicer outputs for four-level mode
        case (rs[5:4])
          2'd0: {d_hi, d_mid, d_lo} = 3'b000;
          2'd1: {d_hi, d_mid, d_lo} = 3'b001;
          2'd2: {d_hi, d_mid, d_lo} = 3'b011;
          default: {d_hi, d_mid, d_lo} = 3'b111;
        endcase
      end
      {e_zero, e_pos, e_neg} = rs[9:7];
      #1;
      chk("R8 in_ready", 8'(in_ready), 8'(!m_dv || dec_ready));
      // model the coming edge
      acc   = in_valid && (!m_dv || dec_ready);
      flush = pam4_mode != m_mode;
      s1e   = flush ? 2'd0 : m_s1;
      s2e   = flush ? 2'd0 : m_s2;
      cnt_e = flush ? 0 : m_cnt;
      prev  = s1e[0];
      if (pam4_mode) cur = {d_mid, d_mid ? d_hi : d_lo};   // R2
      else           cur = {1'b0, prev ? d_hi : d_lo};     // R1
      qual = 1'b0; smp = 1'b0;
      if (pam4_mode) begin
        rise  = cur > s1e;
        m_tag = (cnt_e < 1) ? "R6" : "R4 R5";
        if (cnt_e >= 1 && cur != s1e) begin
          if (cur + s1e == 2'd3 && cur != s1e && (cur ^ s1e) == 2'b11) begin qual = 1; smp = e_zero; end
          else if (cur >= 2 && s1e >= 2) begin qual = 1; smp = e_pos; end
          else if (cur <= 1 && s1e <= 1) begin qual = 1; smp = e_neg; end
        end
      end else begin
        rise  = cur[0];
        m_tag = (cnt_e < 2) ? "R6" : "R3 R5";
        if (cnt_e >= 2 && cur[0] != s1e[0]) begin
          qual = 1;
          if (s2e[0] != s1e[0]) smp = e_zero;
          else if (s1e[0])      smp = e_pos;
          else                  smp = e_neg;
        end
      end
      m_mode  = pam4_mode;
      m_early = acc && qual && (smp == rise);
      m_late  = acc && qual && (smp != rise);
      if (acc) begin
        m_s2 = s1e; m_s1 = cur; m_cnt = (cnt_e >= 2) ? 2 : cnt_e + 1;
        m_dv = 1'b1; m_data = cur;
      end else begin
        m_s2 = s2e; m_s1 = s1e; m_cnt = cnt_e;
        if (dec_ready) m_dv = 1'b0;
      end
      if (!acc) m_tag = "R7";
      @(negedge clk);
    end
    done = 1;
    summary();
  end
endmodule